// File: doc/BRIEF.md
# Real-to-Absolute Prefix Translator

This block turns real storage addresses into absolute addresses on behalf of one processor. Each processor owns a prefix value that names an 8 KiB area in absolute storage, made of two 4 KiB pages. The translator exchanges that area with the lowest 8 KiB of real storage, in both directions. A real address that falls in the low 8 KiB is moved to the prefix area. A real address that falls in the prefix area is moved down to the bottom of storage. Every other address comes out as it went in.

The prefix is loaded through a one-cycle write strobe. On the way in, the register clears every bit that lies outside the legal field, and its current contents are always visible on a readback port. Addresses arrive with a valid strobe and leave one clock later with a valid strobe. Bit positions below use the usual numbering, where bit 0 is the least significant.

Top module: `real_abs_xlat`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pfx_rd_data`, `out_valid` and `out_addr` are all zero.
- R2: A write stores `pfx_wr_data` with every bit cleared except bits 30 down to 13, and the readback never shows a one in bits 63..31 or 12..0.
- R3: A valid address whose bits 63..13 are all zero leaves with bits 63..13 taken from the prefix.
- R4: A valid address whose bits 63..13 equal prefix bits 63..13 leaves with bits 63..13 cleared to zero.
- R5: A valid address that meets neither condition leaves exactly unchanged.
- R6: Bits 12..0 of every translated address equal bits 12..0 of the address that went in.
- R7: With a zero prefix, every address, including those in the low 8 KiB, leaves unchanged.
- R8: `out_valid` equals `in_valid` of the previous cycle, and `out_addr` keeps its value through any cycle with no valid input.
- R9: A prefix write sampled at one clock edge applies to addresses sampled at the next edge and later. An address sampled at the same edge as the write still uses the old prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pfx_wr_en | input | 1 | Load strobe for the prefix register |
| pfx_wr_data | input | 64 | Value to load; bits outside 30..13 are dropped |
| pfx_rd_data | output | 64 | Current prefix register contents |
| in_valid | input | 1 | Real address is present this cycle |
| in_addr | input | 64 | Real address |
| out_valid | output | 1 | Absolute address is present this cycle |
| out_addr | output | 64 | Absolute address |

## Verification
A corrupted prefix register appears at once on `pfx_rd_data`. At the latest it also appears in the next translated address that falls in either of the two swapped areas, one cycle after that address goes in. A fault in the region decision appears only for addresses on or next to the edges of an area: offsets 0 and 8191 of the low area and of the prefix area, and the addresses just outside them. The stimulus therefore aims a large share of its addresses at those edges, and it moves the prefix while traffic is flowing, so that an update applied one cycle early or late changes an observed output.

// File: rtl/real_abs_xlat_pkg.sv
`timescale 1ns/1ps
package real_abs_xlat_pkg;

  // Which rule a real address falls under.
  typedef enum logic [1:0] {
    ZONE_PASS = 2'd0,  // outside both swapped areas
    ZONE_LOW  = 2'd1,  // low 8 KiB of real storage
    ZONE_PFX  = 2'd2   // area named by the prefix
  } zone_e;

  // Default geometry: 64-bit addresses, two 4 KiB pages per area,
  // prefix field limited to bits 30..13.
  localparam int unsigned DEF_ADDR_W   = 64;
  localparam int unsigned DEF_AREA_LSB = 13;
  localparam int unsigned DEF_PFX_MSB  = 30;

endpackage

// File: rtl/real_abs_xlat_prefix_reg.sv
`timescale 1ns/1ps
module real_abs_xlat_prefix_reg #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned AREA_LSB = 13,
  parameter int unsigned PFX_MSB  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] pfx
);

  // Bits that the register is allowed to hold.
  logic [ADDR_W-1:0] keep_mask;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    if (b >= AREA_LSB && b <= PFX_MSB) begin : g_on
      assign keep_mask[b] = 1'b1;
    end else begin : g_off
      assign keep_mask[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfx <= '0;
    end else if (wr_en) begin
      pfx <= wr_data & keep_mask;
    end
  end

endmodule

// File: rtl/real_abs_xlat_zone.sv
`timescale 1ns/1ps
module real_abs_xlat_zone
  import real_abs_xlat_pkg::*;
#(
  parameter int unsigned HI_W = 51
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] pfx_hi,
  output zone_e           zone
);

  logic is_low;
  logic is_pfx;

  assign is_low = (addr_hi == '0);
  assign is_pfx = (addr_hi == pfx_hi);

  // The low area wins when both match (zero prefix); replacing zero with
  // a zero prefix leaves the address unchanged either way.
  always_comb begin
    if (is_low) begin
      zone = ZONE_LOW;
    end else if (is_pfx) begin
      zone = ZONE_PFX;
    end else begin
      zone = ZONE_PASS;
    end
  end

endmodule

// File: rtl/real_abs_xlat_remap.sv
`timescale 1ns/1ps
module real_abs_xlat_remap
  import real_abs_xlat_pkg::*;
#(
  parameter int unsigned HI_W = 51
) (
  input  zone_e           zone,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] pfx_hi,
  output logic [HI_W-1:0] abs_hi
);

  always_comb begin
    unique case (zone)
      ZONE_LOW: abs_hi = pfx_hi;
      ZONE_PFX: abs_hi = '0;
      default:  abs_hi = addr_hi;
    endcase
  end

endmodule

// File: rtl/real_abs_xlat.sv
`timescale 1ns/1ps
module real_abs_xlat
  import real_abs_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned AREA_LSB = DEF_AREA_LSB,
  parameter int unsigned PFX_MSB  = DEF_PFX_MSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pfx_wr_en,
  input  logic [ADDR_W-1:0] pfx_wr_data,
  output logic [ADDR_W-1:0] pfx_rd_data,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);

  localparam int unsigned HI_W = ADDR_W - AREA_LSB;

  logic [ADDR_W-1:0] pfx_q;
  zone_e             zone;
  logic [HI_W-1:0]   abs_hi;

  real_abs_xlat_prefix_reg #(
    .ADDR_W  (ADDR_W),
    .AREA_LSB(AREA_LSB),
    .PFX_MSB (PFX_MSB)
  ) u_pfx (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (pfx_wr_en),
    .wr_data(pfx_wr_data),
    .pfx    (pfx_q)
  );

  real_abs_xlat_zone #(.HI_W(HI_W)) u_zone (
    .addr_hi(in_addr[ADDR_W-1:AREA_LSB]),
    .pfx_hi (pfx_q[ADDR_W-1:AREA_LSB]),
    .zone   (zone)
  );

  real_abs_xlat_remap #(.HI_W(HI_W)) u_remap (
    .zone   (zone),
    .addr_hi(in_addr[ADDR_W-1:AREA_LSB]),
    .pfx_hi (pfx_q[ADDR_W-1:AREA_LSB]),
    .abs_hi (abs_hi)
  );

  // Output stage: one register, address held between valid beats.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= {abs_hi, in_addr[AREA_LSB-1:0]};
      end
    end
  end

  assign pfx_rd_data = pfx_q;

endmodule

// File: rtl/real_abs_xlat_chk.sv
`timescale 1ns/1ps
module real_abs_xlat_chk #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned AREA_LSB = 13,
  parameter int unsigned PFX_MSB  = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              pfx_wr_en,
  input logic [ADDR_W-1:0] pfx_wr_data,
  input logic [ADDR_W-1:0] pfx_rd_data,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr
);

  localparam int unsigned HI_W = ADDR_W - AREA_LSB;

  // R2
  pfx_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pfx_rd_data[ADDR_W-1:PFX_MSB+1] == '0) && (pfx_rd_data[AREA_LSB-1:0] == '0));

  // R3
  low_to_pfx_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr[ADDR_W-1:AREA_LSB] == '0) |=>
      out_addr[ADDR_W-1:AREA_LSB] == $past(pfx_rd_data[ADDR_W-1:AREA_LSB]));

  // R4
  pfx_to_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr[ADDR_W-1:AREA_LSB] == pfx_rd_data[ADDR_W-1:AREA_LSB]) |=>
      out_addr[ADDR_W-1:AREA_LSB] == {HI_W{1'b0}});

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr[ADDR_W-1:AREA_LSB] != '0 &&
     in_addr[ADDR_W-1:AREA_LSB] != pfx_rd_data[ADDR_W-1:AREA_LSB]) |=>
      out_addr == $past(in_addr));

  // R6
  offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_addr[AREA_LSB-1:0] == $past(in_addr[AREA_LSB-1:0]));

  // R7
  zero_pfx_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pfx_rd_data == '0) |=> out_addr == $past(in_addr));

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_addr));

  // R9
  pfx_load_chk: assert property (@(posedge clk) disable iff (rst)
    pfx_wr_en |=> pfx_rd_data[PFX_MSB:AREA_LSB] == $past(pfx_wr_data[PFX_MSB:AREA_LSB]));

  // R9
  pfx_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !pfx_wr_en |=> $stable(pfx_rd_data));

endmodule

bind real_abs_xlat real_abs_xlat_chk #(
  .ADDR_W  (ADDR_W),
  .AREA_LSB(AREA_LSB),
  .PFX_MSB (PFX_MSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pfx_wr_en  (pfx_wr_en),
  .pfx_wr_data(pfx_wr_data),
  .pfx_rd_data(pfx_rd_data),
  .in_valid   (in_valid),
  .in_addr    (in_addr),
  .out_valid  (out_valid),
  .out_addr   (out_addr)
);

// File: tb/real_abs_xlat_bench.sv
`timescale 1ns/1ps
module real_abs_xlat_bench;

  localparam logic [63:0] PMASK = 64'h0000_0000_7FFF_E000;
  localparam logic [63:0] HIGH  = 64'hFFFF_FFFF_FFFF_E000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pfx_wr_en = 1'b0;
  logic [63:0] pfx_wr_data = '0;
  logic [63:0] pfx_rd_data;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic        out_valid;
  logic [63:0] out_addr;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [63:0] m_pfx = '0;
  logic [63:0] m_out = '0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  real_abs_xlat u_real_abs_xlat (
    .clk(clk), .rst(rst),
    .pfx_wr_en(pfx_wr_en), .pfx_wr_data(pfx_wr_data), .pfx_rd_data(pfx_rd_data),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [63:0] ref_xlat(logic [63:0] a, logic [63:0] p);
    if ((a & HIGH) == 64'd0)              return p | (a & ~HIGH);
    else if ((a & HIGH) == (p & HIGH))    return a & ~HIGH;
    else                                  return a;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(bit we, logic [63:0] wd, bit v, logic [63:0] a, string req);
    @(negedge clk);
    pfx_wr_en   = we;
    pfx_wr_data = wd;
    in_valid    = v;
    in_addr     = a;
    if (v) m_out = ref_xlat(a, m_pfx);   // R9: address sees old prefix
    if (we) m_pfx = wd & PMASK;          // R2
    @(posedge clk);
    #1;
    chk({req, "/R8 valid"}, {63'd0, out_valid}, {63'd0, v});
    chk({req, " addr"}, out_addr, m_out);
    chk("R2 readback", pfx_rd_data, m_pfx);
  endtask

  function automatic logic [63:0] pick_addr(logic [63:0] p);
    logic [63:0] off = {51'd0, 13'($urandom)};
    case ($urandom % 8)
      0: return off;
      1: return p | off;
      2: return 64'h0000_0000_0000_2000;
      3: return (p & HIGH) - 64'd1;
      4: return (p & HIGH) + 64'h2000;
      5: return 64'h0000_0000_0000_1FFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 prefix", pfx_rd_data, 64'd0);
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 addr", out_addr, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 after release", out_addr, 64'd0);

    // R7: zero prefix, low area unchanged
    step(0, '0, 1, 64'h0000_0000_0000_0ABC, "R7 low");
    chk("R7 identity", out_addr, 64'h0000_0000_0000_0ABC);
    step(0, '0, 1, 64'h1234_5678_9ABC_DEF0, "R7 other");

    // R2: all-ones write keeps only bits 30..13
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, '0, "R2 write");
    chk("R2 masked", pfx_rd_data, 64'h0000_0000_7FFF_E000);
    // R8: address held while idle
    step(0, '0, 0, 64'hDEAD_BEEF_0000_0000, "R8 idle");

    // R9: write and address at the same edge, then the next edge
    step(1, 64'h0000_0000_0004_6000, 1, 64'h0000_0000_0000_0010, "R9 same edge");
    chk("R9 old prefix", out_addr, 64'h0000_0000_7FFF_E010);
    step(0, '0, 1, 64'h0000_0000_0000_0010, "R9 next edge");
    chk("R9 new prefix", out_addr, 64'h0000_0000_0004_6010);

    // R3 / R4 / R6 edges of the areas
    step(0, '0, 1, 64'h0000_0000_0000_1FFF, "R3 low top");
    chk("R3 low top", out_addr, 64'h0000_0000_0004_7FFF);
    step(0, '0, 1, 64'h0000_0000_0004_7FFF, "R4 pfx top");
    chk("R4 pfx top", out_addr, 64'h0000_0000_0000_1FFF);
    step(0, '0, 1, 64'h0000_0000_0004_5FFF, "R5 below pfx");
    step(0, '0, 1, 64'h0000_0000_0004_8000, "R5 above pfx");
    step(0, '0, 1, 64'h0000_0000_0000_2000, "R5 above low");
    step(0, '0, 1, 64'h8000_0000_0004_6123, "R5 high bit");
    step(0, '0, 1, 64'h0000_0000_0004_6000, "R6 pfx base");

    // Constrained random mix with live prefix changes
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 10) == 0;
      logic [63:0] wd = (($urandom % 6) == 0) ? 64'd0 : {$urandom, $urandom};
      bit v = ($urandom % 4) != 0;
      step(we, wd, v, pick_addr(m_pfx), "R3-6 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule